// File: doc/BRIEF.md
# Dual Lockable Translation Buffer with Based Victim Replacement

The block keeps two small fully associative translation buffers side by side: bank D for data accesses and bank I for instruction accesses. Each bank maps a 20-bit virtual page number to a 20-bit physical page number. Each bank has its own lookup port, which returns hit and the physical page in the same cycle, and its own refill port. A refill writes the slot that the bank's victim pointer names and then moves the pointer on.

A coprocessor-style port carries a register number, a 3-bit secondary opcode, a 4-bit sub-register code and 32 bits of data. Writes to register 8 are maintenance commands. A full flush invalidates every entry of a bank except the entries marked as kept. A flush by address invalidates the matching entries whether or not they are kept. Register 10 holds each bank's lock control: a replacement base, the current victim pointer and a keep flag. When the pointer passes the last slot it returns to the base, so the slots below the base are never chosen for replacement and act as locked entries.

Top module: `tlbx_pair`

## Requirements
- R1: After reset every entry of both banks is invalid, so every lookup misses. The lock control of both banks reads as all zero.
- R2: A lookup hits when a valid entry of that bank holds the requested virtual page, and it returns that entry's physical page in the same cycle. If several entries match, the lowest-numbered slot wins.
- R3: A refill stores the page pair in the slot named by the bank's victim pointer. Unless it passes the last slot (7), the pointer then increments by one.
- R4: A refill at slot 7 sends the victim pointer back to the base value, not to zero.
- R5: An entry written by a refill has its keep flag set if the bank's lock-control keep bit is set at that moment, and clear otherwise.
- R6: A write to register 8 with opcode 0 invalidates every non-kept entry of one bank and leaves kept entries valid. Code 5 targets bank I and code 6 targets bank D.
- R7: A write to register 8 with opcode 1 invalidates the entries whose virtual page equals data bits 31:12, whether or not they are kept. Code 5 targets bank I and code 6 targets bank D. All other entries are left alone.
- R8: A write to register 8 with opcode 0 and code 7 performs the full flush of R6 on both banks at once.
- R9: The banks are independent. In register 10, opcode 0 selects bank D and opcode 1 selects bank I. A command aimed at one bank never changes the other bank.
- R10: Any register-8 opcode/code pair not listed above, writes to other register numbers, and register-10 writes with opcode above 1 have no effect. Reads of register 8, and of register 10 with opcode above 1, return zero.
- R11: A register-10 word carries the base in bits 31:29, the victim pointer in bits 28:26 and the keep bit in bit 0. A write loads all three fields together and ignores bits 25:1. A read returns all three fields, with bits 25:1 as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_wr | input | 1 | Coprocessor write strobe |
| cp_rd | input | 1 | Coprocessor read enable |
| cp_reg | input | 4 | Register number |
| cp_op2 | input | 3 | Secondary opcode |
| cp_crm | input | 4 | Sub-register code |
| cp_wdata | input | 32 | Write data (flush address or lock word) |
| cp_rdata | output | 32 | Read data, combinational |
| i_look_vpn | input | 20 | Bank I lookup virtual page |
| i_look_hit | output | 1 | Bank I hit |
| i_look_ppn | output | 20 | Bank I physical page |
| i_fill_en | input | 1 | Bank I refill strobe |
| i_fill_vpn | input | 20 | Bank I refill virtual page |
| i_fill_ppn | input | 20 | Bank I refill physical page |
| d_look_vpn | input | 20 | Bank D lookup virtual page |
| d_look_hit | output | 1 | Bank D hit |
| d_look_ppn | output | 20 | Bank D physical page |
| d_fill_en | input | 1 | Bank D refill strobe |
| d_fill_vpn | input | 20 | Bank D refill virtual page |
| d_fill_ppn | input | 20 | Bank D refill physical page |

## Verification
The hardest state to reach is a bank that holds both kept and unkept entries while its victim pointer sits just before a wrap to a non-zero base. Only then can a flush that spares the kept entries, and a wrap that skips the locked slots, both be seen at the ports. The stimulus first fills a bank completely, then writes a lock word with base 3 and the keep bit set and refills twice. It then rewrites the lock word with the keep bit clear and the pointer at 5, and refills until the pointer wraps. After every operation the bench compares a full sweep of lookups over every stored page, plus both lock words, against an arithmetic model.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
    localparam int unsigned ENTRIES  = 8;
    localparam int unsigned IDX_W    = $clog2(ENTRIES);
    localparam int unsigned DW       = 32;
    localparam int unsigned VPN_W    = 20;
    localparam int unsigned PPN_W    = 20;
    localparam int unsigned NBANK    = 2;
    localparam int unsigned BANK_D   = 0;
    localparam int unsigned BANK_I   = 1;
    localparam int unsigned PAD_W    = DW - 2*IDX_W - 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    localparam logic [3:0] REG_MAINT = 4'd8;
    localparam logic [3:0] REG_LOCK  = 4'd10;

    typedef struct packed {
        logic             valid;
        logic             keep;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;

    typedef struct packed {
        logic [IDX_W-1:0] base;
        logic [IDX_W-1:0] victim;
        logic             keep;
    } lock_t;

    function automatic logic [DW-1:0] pack_lock(input lock_t l);
        return {l.base, l.victim, {PAD_W{1'b0}}, l.keep};
    endfunction

    function automatic lock_t unpack_lock(input logic [DW-1:0] d);
        lock_t l;
        l.base   = d[DW-1 -: IDX_W];
        l.victim = d[DW-1-IDX_W -: IDX_W];
        l.keep   = d[0];
        return l;
    endfunction
endpackage

// File: rtl/tlbx_cp_decode.sv
module tlbx_cp_decode
    import tlbx_pkg::*;
(
    input  logic             cp_wr,
    input  logic [3:0]       cp_reg,
    input  logic [2:0]       cp_op2,
    input  logic [3:0]       cp_crm,
    output logic [NBANK-1:0] flush_all,
    output logic [NBANK-1:0] flush_va,
    output logic [NBANK-1:0] lock_wr
);
    always_comb begin
        flush_all = '0;
        flush_va  = '0;
        lock_wr   = '0;
        if (cp_wr && cp_reg == REG_MAINT) begin
            case ({cp_op2, cp_crm})
                7'b000_0101: flush_all[BANK_I] = 1'b1;
                7'b001_0101: flush_va[BANK_I]  = 1'b1;
                7'b000_0110: flush_all[BANK_D] = 1'b1;
                7'b001_0110: flush_va[BANK_D]  = 1'b1;
                7'b000_0111: flush_all         = '1;
                default: ;
            endcase
        end
        if (cp_wr && cp_reg == REG_LOCK) begin
            if (cp_op2 == 3'd0) lock_wr[BANK_D] = 1'b1;
            if (cp_op2 == 3'd1) lock_wr[BANK_I] = 1'b1;
        end
    end
endmodule

// File: rtl/tlbx_match.sv
module tlbx_match
    import tlbx_pkg::*;
(
    input  tlb_entry_t [ENTRIES-1:0] ents,
    input  logic [VPN_W-1:0]         vpn,
    output logic                     hit,
    output logic [PPN_W-1:0]         ppn
);
    always_comb begin
        hit = 1'b0;
        ppn = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (ents[i].valid && ents[i].vpn == vpn) begin
                hit = 1'b1;
                ppn = ents[i].ppn;
            end
        end
    end
endmodule

// File: rtl/tlbx_bank.sv
module tlbx_bank
    import tlbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             look_hit,
    output logic [PPN_W-1:0] look_ppn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             flush_all,
    input  logic             flush_va,
    input  logic [VPN_W-1:0] flush_vpn,
    input  logic             lock_wr,
    input  lock_t            lock_wdata,
    output lock_t            lock_q
);
    tlb_entry_t [ENTRIES-1:0] ent_q;
    logic [IDX_W-1:0]         victim_nxt;

    assign victim_nxt = (lock_q.victim == LAST_IDX) ? lock_q.base
                                                    : lock_q.victim + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= '0;
        end else if (lock_wr) begin
            lock_q <= lock_wdata;
        end else if (fill_en) begin
            lock_q.victim <= victim_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (fill_en && lock_q.victim == IDX_W'(i)) begin
                    ent_q[i].valid <= 1'b1;
                    ent_q[i].keep  <= lock_q.keep;
                    ent_q[i].vpn   <= fill_vpn;
                    ent_q[i].ppn   <= fill_ppn;
                end else if ((flush_all && !ent_q[i].keep) ||
                             (flush_va && ent_q[i].vpn == flush_vpn)) begin
                    ent_q[i].valid <= 1'b0;
                end
            end
        end
    end

    tlbx_match u_match (
        .ents (ent_q),
        .vpn  (look_vpn),
        .hit  (look_hit),
        .ppn  (look_ppn)
    );

    AST_VICTIM_STEP: assert property (@(posedge clk) disable iff (rst)
        fill_en && !lock_wr && lock_q.victim != LAST_IDX
        |=> lock_q.victim == IDX_W'($past(lock_q.victim) + 1'b1)); // R3
    AST_VICTIM_WRAP: assert property (@(posedge clk) disable iff (rst)
        fill_en && !lock_wr && lock_q.victim == LAST_IDX
        |=> lock_q.victim == $past(lock_q.base)); // R4
    AST_FILL_KEEP: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> ent_q[$past(lock_q.victim)].valid &&
                    ent_q[$past(lock_q.victim)].keep == $past(lock_q.keep)); // R5
    AST_LOCK_LOAD: assert property (@(posedge clk) disable iff (rst)
        lock_wr |=> lock_q == $past(lock_wdata)); // R11

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent_chk
        AST_FLUSH_SPARES: assert property (@(posedge clk) disable iff (rst)
            flush_all && !flush_va && ent_q[g].valid && ent_q[g].keep
            |=> ent_q[g].valid); // R6
        AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (rst)
            flush_all && !ent_q[g].keep &&
            !(fill_en && lock_q.victim == IDX_W'(g))
            |=> !ent_q[g].valid); // R6
        AST_FLUSH_ADDR: assert property (@(posedge clk) disable iff (rst)
            flush_va && ent_q[g].vpn == flush_vpn &&
            !(fill_en && lock_q.victim == IDX_W'(g))
            |=> !ent_q[g].valid); // R7
    end
endmodule

// File: rtl/tlbx_pair.sv
module tlbx_pair
    import tlbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cp_wr,
    input  logic              cp_rd,
    input  logic [3:0]        cp_reg,
    input  logic [2:0]        cp_op2,
    input  logic [3:0]        cp_crm,
    input  logic [DW-1:0]     cp_wdata,
    output logic [DW-1:0]     cp_rdata,
    input  logic [VPN_W-1:0]  i_look_vpn,
    output logic              i_look_hit,
    output logic [PPN_W-1:0]  i_look_ppn,
    input  logic              i_fill_en,
    input  logic [VPN_W-1:0]  i_fill_vpn,
    input  logic [PPN_W-1:0]  i_fill_ppn,
    input  logic [VPN_W-1:0]  d_look_vpn,
    output logic              d_look_hit,
    output logic [PPN_W-1:0]  d_look_ppn,
    input  logic              d_fill_en,
    input  logic [VPN_W-1:0]  d_fill_vpn,
    input  logic [PPN_W-1:0]  d_fill_ppn
);
    logic [NBANK-1:0] flush_all, flush_va, lock_wr;
    logic [NBANK-1:0] fill_en, look_hit;
    logic [VPN_W-1:0] look_vpn [NBANK];
    logic [VPN_W-1:0] fill_vpn [NBANK];
    logic [PPN_W-1:0] fill_ppn [NBANK];
    logic [PPN_W-1:0] look_ppn [NBANK];
    lock_t            lock_q   [NBANK];
    lock_t            lock_wdata;
    logic [VPN_W-1:0] flush_vpn;

    assign lock_wdata = unpack_lock(cp_wdata);
    assign flush_vpn  = cp_wdata[DW-1 -: VPN_W];

    assign look_vpn[BANK_I] = i_look_vpn;
    assign look_vpn[BANK_D] = d_look_vpn;
    assign fill_en[BANK_I]  = i_fill_en;
    assign fill_en[BANK_D]  = d_fill_en;
    assign fill_vpn[BANK_I] = i_fill_vpn;
    assign fill_vpn[BANK_D] = d_fill_vpn;
    assign fill_ppn[BANK_I] = i_fill_ppn;
    assign fill_ppn[BANK_D] = d_fill_ppn;
    assign i_look_hit = look_hit[BANK_I];
    assign i_look_ppn = look_ppn[BANK_I];
    assign d_look_hit = look_hit[BANK_D];
    assign d_look_ppn = look_ppn[BANK_D];

    tlbx_cp_decode u_dec (
        .cp_wr     (cp_wr),
        .cp_reg    (cp_reg),
        .cp_op2    (cp_op2),
        .cp_crm    (cp_crm),
        .flush_all (flush_all),
        .flush_va  (flush_va),
        .lock_wr   (lock_wr)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        tlbx_bank u_bank (
            .clk        (clk),
            .rst        (rst),
            .look_vpn   (look_vpn[b]),
            .look_hit   (look_hit[b]),
            .look_ppn   (look_ppn[b]),
            .fill_en    (fill_en[b]),
            .fill_vpn   (fill_vpn[b]),
            .fill_ppn   (fill_ppn[b]),
            .flush_all  (flush_all[b]),
            .flush_va   (flush_va[b]),
            .flush_vpn  (flush_vpn),
            .lock_wr    (lock_wr[b]),
            .lock_wdata (lock_wdata),
            .lock_q     (lock_q[b])
        );
    end

    // opcode 0 selects bank D (index 0), opcode 1 selects bank I (index 1)
    always_comb begin
        cp_rdata = '0;
        if (cp_rd && cp_reg == REG_LOCK && cp_op2 < 3'd2)
            cp_rdata = pack_lock(lock_q[cp_op2[0]]);
    end

    AST_NO_CROSS_LOCK: assert property (@(posedge clk) disable iff (rst)
        lock_wr[BANK_I] |=> lock_q[BANK_D] == $past(lock_q[BANK_D]) ||
                            $past(fill_en[BANK_D])); // R9
endmodule

// File: tb/tlbx_pair_bench.sv
module tlbx_pair_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cp_wr = 0, cp_rd = 0;
    logic [3:0]  cp_reg = 0;
    logic [2:0]  cp_op2 = 0;
    logic [3:0]  cp_crm = 0;
    logic [31:0] cp_wdata = 0;
    logic [31:0] cp_rdata;
    logic [19:0] i_look_vpn = 0, d_look_vpn = 0;
    logic        i_look_hit, d_look_hit;
    logic [19:0] i_look_ppn, d_look_ppn;
    logic        i_fill_en = 0, d_fill_en = 0;
    logic [19:0] i_fill_vpn = 0, i_fill_ppn = 0, d_fill_vpn = 0, d_fill_ppn = 0;

    int checks = 0;
    int errors = 0;

    // bench model, index 0 = bank D, 1 = bank I
    bit          mv   [2][8];
    bit          mk   [2][8];
    logic [19:0] mvpn [2][8];
    logic [19:0] mppn [2][8];
    logic [2:0]  mbase [2];
    logic [2:0]  mvic  [2];
    bit          mkeep [2];

    always #2.5 clk = ~clk;

    tlbx_pair u_tlbx_pair (.*);

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cp_write(input logic [3:0] r, input logic [2:0] o, input logic [3:0] c,
                            input logic [31:0] d);
        @(negedge clk);
        cp_wr = 1; cp_reg = r; cp_op2 = o; cp_crm = c; cp_wdata = d;
        @(negedge clk);
        cp_wr = 0;
    endtask

    task automatic cp_read(input logic [3:0] r, input logic [2:0] o, output logic [31:0] d);
        @(negedge clk);
        cp_rd = 1; cp_reg = r; cp_op2 = o;
        #1 d = cp_rdata;
        cp_rd = 0;
    endtask

    function automatic void m_fill(int b, logic [19:0] v, logic [19:0] p);
        int s = int'(mvic[b]);
        mv[b][s] = 1; mk[b][s] = mkeep[b]; mvpn[b][s] = v; mppn[b][s] = p;
        mvic[b] = (mvic[b] == 3'd7) ? mbase[b] : mvic[b] + 3'd1;
    endfunction

    function automatic void m_flush_all(int b);
        for (int k = 0; k < 8; k++) if (!mk[b][k]) mv[b][k] = 0;
    endfunction

    function automatic void m_flush_va(int b, logic [19:0] v);
        for (int k = 0; k < 8; k++) if (mvpn[b][k] == v) mv[b][k] = 0;
    endfunction

    task automatic fill(input int b, input logic [19:0] v);
        logic [19:0] p = v ^ 20'h5A5A5;
        @(negedge clk);
        if (b == 0) begin d_fill_en = 1; d_fill_vpn = v; d_fill_ppn = p; end
        else        begin i_fill_en = 1; i_fill_vpn = v; i_fill_ppn = p; end
        @(negedge clk);
        d_fill_en = 0; i_fill_en = 0;
        m_fill(b, v, p);
    endtask

    task automatic set_lock(input int b, input logic [2:0] base, input logic [2:0] vic,
                            input bit kp);
        // bits 25:1 carry junk that must be ignored
        cp_write(4'd10, 3'(b), 4'd0, {base, vic, 25'h0AAAAAA, kp} | 32'h0155_5554);
        mbase[b] = base; mvic[b] = vic; mkeep[b] = kp;
    endtask

    task automatic probe(input string tag, input int b, input logic [19:0] v);
        bit          eh = 0;
        logic [19:0] ep = 0;
        logic        gh;
        logic [19:0] gp;
        for (int k = 7; k >= 0; k--)
            if (mv[b][k] && mvpn[b][k] == v) begin eh = 1; ep = mppn[b][k]; end
        @(negedge clk);
        if (b == 0) d_look_vpn = v; else i_look_vpn = v;
        #1;
        gh = (b == 0) ? d_look_hit : i_look_hit;
        gp = (b == 0) ? d_look_ppn : i_look_ppn;
        check({tag, " hit"}, 32'(gh), 32'(eh));
        if (eh) check({tag, " ppn"}, 32'(gp), 32'(ep));
    endtask

    task automatic check_all(input string tag);
        logic [31:0] rd;
        for (int b = 0; b < 2; b++) begin
            cp_read(4'd10, 3'(b), rd);
            check({tag, " lock word"}, rd, {mbase[b], mvic[b], 25'd0, mkeep[b]});
            for (int k = 0; k < 8; k++) probe(tag, b, mvpn[b][k]);
            for (int k = 0; k < 8; k++) probe(tag, b, mvpn[1-b][k]);
            probe(tag, b, 20'hFFFFF);
        end
    endtask

    initial begin
        logic [31:0] rd;
        for (int b = 0; b < 2; b++) begin
            mbase[b] = 0; mvic[b] = 0; mkeep[b] = 0;
            for (int k = 0; k < 8; k++) begin
                mv[b][k] = 0; mk[b][k] = 0; mvpn[b][k] = 0; mppn[b][k] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 0;
        check_all("R1");

        // fill both banks completely; pointer walks 0..7 then wraps to base 0
        for (int b = 0; b < 2; b++)
            for (int k = 0; k < 8; k++) begin
                fill(b, 20'(b * 256 + 16 + k));
                check_all("R3");
            end
        check_all("R2");

        // lock bank D: base 3, pointer 3, keep set
        set_lock(0, 3'd3, 3'd3, 1'b1);
        check_all("R11");
        fill(0, 20'h00A01);
        fill(0, 20'h00A02);
        check_all("R5");
        set_lock(0, 3'd3, 3'd5, 1'b0);
        for (int k = 0; k < 4; k++) begin
            fill(0, 20'(20'h00B00 + k));
            check_all("R4");
        end

        // lock bank I through opcode 1: base 2, pointer 6, keep set
        set_lock(1, 3'd2, 3'd6, 1'b1);
        fill(1, 20'h00C01);
        fill(1, 20'h00C02);
        check_all("R9");

        // full flush of bank D spares kept slot 4, leaves bank I
        cp_write(4'd8, 3'd0, 4'd6, 32'h0);
        m_flush_all(0);
        check_all("R6");

        // address flush in bank I: kept entry, then an unkept one
        cp_write(4'd8, 3'd1, 4'd5, {20'h00C01, 12'h0});
        m_flush_va(1, 20'h00C01);
        check_all("R7");
        cp_write(4'd8, 3'd1, 4'd5, {20'h00112, 12'hFFF});
        m_flush_va(1, 20'h00112);
        check_all("R7");
        // address flush in bank D of a page only bank I holds: no change
        cp_write(4'd8, 3'd1, 4'd6, {20'h00C02, 12'h0});
        m_flush_va(0, 20'h00C02);
        check_all("R9");

        // undefined commands and stray registers
        cp_write(4'd8, 3'd2, 4'd5, 32'h0);
        cp_write(4'd8, 3'd1, 4'd7, 32'h0);
        cp_write(4'd8, 3'd0, 4'd4, 32'h0);
        cp_write(4'd8, 3'd3, 4'd6, 32'h0);
        cp_write(4'd9, 3'd0, 4'd5, 32'h0);
        cp_write(4'd10, 3'd2, 4'd0, 32'hFFFF_FFFF);
        cp_read(4'd8, 3'd0, rd);
        check("R10 reg8 read", rd, 32'h0);
        cp_read(4'd10, 3'd3, rd);
        check("R10 reg10 op3 read", rd, 32'h0);
        check_all("R10");

        // full flush of bank I, refill, then flush both banks
        cp_write(4'd8, 3'd0, 4'd5, 32'h0);
        m_flush_all(1);
        check_all("R6");
        fill(1, 20'h00D01);
        fill(0, 20'h00D02);
        cp_write(4'd8, 3'd0, 4'd7, 32'h0);
        m_flush_all(0);
        m_flush_all(1);
        check_all("R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule